// File: doc/BRIEF.md
# Banked Privileged System Control Register

This block holds the top-level 32-bit system control word. It keeps one Secure and one Non-secure copy. Software reaches the block through a single-cycle request port. Each request carries a privilege level from 0 to 3, a security-state flag, a read/write flag and write data. The block grants or refuses the request, steers it to the copy that the security flag selects, and answers one cycle later with read data or an error flag.

Some bits have fixed values. Reserved positions are held at 0 or 1, and two read-only compatibility bits keep their reset values, so writes cannot change any of them. An external lock pin refuses writes to the Secure copy while it is high. The exception-state bit, bit 30, takes its reset value from a configuration pin, so the instruction-set state used for exception entry is chosen when the chip is integrated. What each control bit does further downstream is left to the logic that consumes the register.

Top module: `sys_ctrl_bank`

## Requirements
- R1: While `rst_n` is low, both copies load 0x00C50098 with bit 30 replaced by `cfg_exc_state`. This gives 0x40C50098 when that pin is 1 and 0x00C50098 when it is 0.
- R2: A request at privilege level 0 is refused, whether it is a read or a write and whatever its security state. Neither copy changes.
- R3: A request at privilege level 1, 2 or 3 is accepted (R5 gives the one exception). An accepted write updates the selected copy, and an accepted read returns that copy.
- R4: `req_ns` = 1 selects the Non-secure copy and `req_ns` = 0 selects the Secure copy. A write to one copy leaves the other copy unchanged.
- R5: While `sec_wr_lock` is high, a write to the Secure copy is refused and the Secure copy keeps its value. Reads of the Secure copy and writes to the Non-secure copy still work.
- R6: Bits 31, 10 and 9 always read 0. Bits 23, 22, 18, 16, 4 and 3 always read 1. Writes do not change these bits.
- R7: The read-only bits keep their fixed values whatever is written: bit 8 reads 0 and bit 7 reads 1.
- R8: All other bits, bit 30 included (mask 0x7F3AF867), take the written data. An accepted write therefore stores (wdata & 0x7F3AF867) | 0x00C50098.
- R9: `rsp_valid` is high in the cycle after every request and low otherwise. A write takes effect on the clock edge that samples it, so a read issued in the very next cycle returns the new value.
- R10: A refused request raises `rsp_err` for its one response cycle and returns `rsp_rdata` = 0. An accepted write also returns 0, with `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_exc_state | input | 1 | Reset value of the exception-state bit (bit 30) |
| sec_wr_lock | input | 1 | When high, refuses writes to the Secure copy |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Privilege level of the requester, 0 to 3 |
| req_ns | input | 1 | Security state: 1 = Non-secure copy, 0 = Secure copy |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after each request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data; 0 for writes and for refused requests |

## Verification
The assertions assume that every request input is a known value while `req_valid` is high, and that `cfg_exc_state` stays steady during and just after reset. They also treat each request as lasting exactly one cycle. The bench drives all inputs at the falling edge and never leaves a field undefined. It holds the configuration pin constant across each reset period and changes it only between two full resets. It sweeps every combination of privilege, security state, direction and lock across walking-one and mixed data patterns.

// File: rtl/sysctl_pkg.sv
// Package: shared widths, bank indices, fixed-bit masks and the request type
// for the banked system control register. Assumes a two-copy bank.
package sysctl_pkg;
    localparam int unsigned CTL_W     = 32;
    localparam int unsigned PRIV_W    = 2;
    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned BANK_SEC  = 0;
    localparam int unsigned BANK_NS   = 1;
    localparam int unsigned EXC_BIT   = 30;
    localparam int unsigned MIN_PRIV  = 1;

    // Reserved positions forced to zero.
    localparam logic [CTL_W-1:0] RES0_BITS = 32'h8000_0600;
    // Reserved positions forced to one.
    localparam logic [CTL_W-1:0] RES1_BITS = 32'h00C5_0018;
    // Read-only compatibility bits and their fixed values.
    localparam logic [CTL_W-1:0] RO_BITS   = 32'h0000_0180;
    localparam logic [CTL_W-1:0] RO_VALUE  = 32'h0000_0080;

    typedef struct packed {
        logic              write;
        logic [PRIV_W-1:0] priv;
        logic              ns;
        logic [CTL_W-1:0]  wdata;
    } ctl_req_t;
endpackage

// File: rtl/sysctl_access_chk.sv
// Access checker: decides whether a request is accepted, and produces one
// write enable for each bank copy.
// Assumes the request fields are stable in the cycle req_valid is high.
// The bank index is taken directly from the security-state flag.
module sysctl_access_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned PRIV_LEVEL_W = PRIV_W,
    parameter int unsigned LOWEST_OK    = MIN_PRIV,
    parameter int unsigned BANKS        = NUM_BANKS,
    parameter int unsigned SEC_INDEX    = BANK_SEC
) (
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [PRIV_LEVEL_W-1:0] req_priv,
    input  logic                    req_ns,
    input  logic                    sec_lock,
    output logic                    accept,
    output logic                    reject,
    output logic [BANKS-1:0]        bank_wr_en
);
    localparam logic [PRIV_LEVEL_W-1:0] LOWEST = PRIV_LEVEL_W'(LOWEST_OK);

    logic priv_ok;
    logic lock_hit;

    // Privilege test and Secure write-lock test.
    always_comb begin
        priv_ok  = (req_priv >= LOWEST);
        lock_hit = req_write && (32'(req_ns) == SEC_INDEX) && sec_lock;
        accept   = req_valid && priv_ok && !lock_hit;
        reject   = req_valid && !accept;
    end

    // One write enable per copy, chosen by the security-state flag.
    for (genvar b = 0; b < BANKS; b++) begin : g_wen
        always_comb bank_wr_en[b] = accept && req_write && (32'(req_ns) == b);
    end
endmodule

// File: rtl/sysctl_bank_reg.sv
// One copy of the control word. It applies the writable mask, forces the
// reserved bits and keeps the read-only bits at their reset values. Its reset
// value takes the exception-state bit from a configuration input.
// Assumes cfg_exc is steady while rst_n is low.
module sysctl_bank_reg
    import sysctl_pkg::*;
#(
    parameter int unsigned     W        = CTL_W,
    parameter logic [W-1:0]    ZERO_MSK = RES0_BITS,
    parameter logic [W-1:0]    ONE_MSK  = RES1_BITS,
    parameter logic [W-1:0]    RO_MSK   = RO_BITS,
    parameter logic [W-1:0]    RO_VAL   = RO_VALUE,
    parameter int unsigned     EXC_POS  = EXC_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_exc,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] FIXED_MSK = ZERO_MSK | ONE_MSK | RO_MSK;
    localparam logic [W-1:0] WR_MSK    = ~FIXED_MSK;
    localparam logic [W-1:0] FIXED_VAL = ONE_MSK | (RO_VAL & RO_MSK);

    logic [W-1:0] rst_val;
    logic [W-1:0] merged;

    // Reset value: the fixed pattern plus the configured exception-state bit.
    always_comb begin
        rst_val          = FIXED_VAL;
        rst_val[EXC_POS] = cfg_exc;
    end

    // Masked merge of write data, then force the reserved bits.
    always_comb merged = (((q & ~WR_MSK) | (wdata & WR_MSK)) | ONE_MSK) & ~ZERO_MSK;

    // Storage update: load on reset, otherwise on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= rst_val;
        else if (wr_en) q <= merged;
    end
endmodule

// File: rtl/sys_ctrl_bank.sv
// Top: banked system control register with a one-cycle request port.
// Holds a Secure and a Non-secure copy, checks privilege, refuses Secure
// writes while locked, and registers the response one cycle after the request.
// Assumes each request lasts one cycle and has known fields.
module sys_ctrl_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned          DATA_W   = CTL_W,
    parameter int unsigned          LEVEL_W  = PRIV_W,
    parameter logic [DATA_W-1:0]    ZERO_MSK = RES0_BITS,
    parameter logic [DATA_W-1:0]    ONE_MSK  = RES1_BITS,
    parameter logic [DATA_W-1:0]    RO_MSK   = RO_BITS,
    parameter logic [DATA_W-1:0]    RO_VAL   = RO_VALUE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_exc_state,
    input  logic               sec_wr_lock,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [LEVEL_W-1:0] req_priv,
    input  logic               req_ns,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata
);
    logic                 accept;
    logic                 reject;
    logic [NUM_BANKS-1:0] bank_wr_en;
    logic [DATA_W-1:0]    bank_q [NUM_BANKS];
    logic [DATA_W-1:0]    sel_q;

    sysctl_access_chk #(
        .PRIV_LEVEL_W (LEVEL_W),
        .LOWEST_OK    (MIN_PRIV),
        .BANKS        (NUM_BANKS),
        .SEC_INDEX    (BANK_SEC)
    ) u_access (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_priv   (req_priv),
        .req_ns     (req_ns),
        .sec_lock   (sec_wr_lock),
        .accept     (accept),
        .reject     (reject),
        .bank_wr_en (bank_wr_en)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sysctl_bank_reg #(
            .W        (DATA_W),
            .ZERO_MSK (ZERO_MSK),
            .ONE_MSK  (ONE_MSK),
            .RO_MSK   (RO_MSK),
            .RO_VAL   (RO_VAL),
            .EXC_POS  (EXC_BIT)
        ) u_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_exc (cfg_exc_state),
            .wr_en   (bank_wr_en[b]),
            .wdata   (req_wdata),
            .q       (bank_q[b])
        );
    end

    // Read mux: pick the copy named by the security-state flag.
    always_comb sel_q = bank_q[req_ns];

    // Response register: valid, error and read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= reject;
            rsp_rdata <= (accept && !req_write) ? sel_q : '0;
        end
    end
endmodule

// File: rtl/sysctl_chk.sv
// Checker for sys_ctrl_bank: ports and both stored copies are watched over time.
// Assumes known request inputs while req_valid is high.
module sysctl_chk #(
    parameter int unsigned       W        = 32,
    parameter int unsigned       LEVEL_W  = 2,
    parameter logic [W-1:0]      ZERO_MSK = 32'h8000_0600,
    parameter logic [W-1:0]      ONE_MSK  = 32'h00C5_0018
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sec_wr_lock,
    input logic               req_valid,
    input logic               req_write,
    input logic [LEVEL_W-1:0] req_priv,
    input logic               req_ns,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [W-1:0]       rsp_rdata,
    input logic [W-1:0]       sec_q,
    input logic [W-1:0]       ns_q
);
    assert_priv0_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == '0) |=> (rsp_err && $stable(sec_q) && $stable(ns_q)));

    assert_sec_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_ns && sec_wr_lock) |=> (rsp_err && $stable(sec_q)));

    assert_other_copy_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ns) |=> $stable(sec_q));

    assert_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && rsp_rdata != '0) |->
            (((rsp_rdata & ONE_MSK) == ONE_MSK) && ((rsp_rdata & ZERO_MSK) == '0)));

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

bind sys_ctrl_bank sysctl_chk #(
    .W        (DATA_W),
    .LEVEL_W  (LEVEL_W),
    .ZERO_MSK (ZERO_MSK),
    .ONE_MSK  (ONE_MSK)
) u_sysctl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_wr_lock (sec_wr_lock),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_priv    (req_priv),
    .req_ns      (req_ns),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .sec_q       (bank_q[0]),
    .ns_q        (bank_q[1])
);

// File: tb/test_sys_ctrl_bank.sv
// Bench: sweeps privilege, security state, direction and lock over many data
// patterns, tracking both copies arithmetically from the requirements.
module test_sys_ctrl_bank;
    localparam logic [31:0] WMASK = 32'h7F3A_F867;
    localparam logic [31:0] FIXV  = 32'h00C5_0098;
    localparam logic [31:0] Z_MSK = 32'h8000_0600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_exc_state = 1'b1;
    logic        sec_wr_lock = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_priv = 2'd0;
    logic        req_ns = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] mdl [2];

    always #4 clk = ~clk;

    sys_ctrl_bank i_sys_ctrl_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_exc_state (cfg_exc_state),
        .sec_wr_lock   (sec_wr_lock),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_priv      (req_priv),
        .req_ns        (req_ns),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_rdata     (rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // One request driven at a falling edge; its response is checked one cycle later.
    task automatic access(input bit wr, input logic [1:0] pv, input bit ns,
                          input logic [31:0] wd, input bit lk);
        bit          bad;
        logic [31:0] exp_rd;
        string       tag;
        bad    = (pv == 2'd0) || (wr && !ns && lk);
        exp_rd = (!bad && !wr) ? mdl[ns] : 32'h0;
        tag    = (pv == 2'd0) ? "R2" : ((wr && !ns && lk) ? "R5" : (wr ? "R8" : "R3 R4"));
        req_valid   = 1'b1;
        req_write   = wr;
        req_priv    = pv;
        req_ns      = ns;
        req_wdata   = wd;
        sec_wr_lock = lk;
        @(negedge clk);
        req_valid = 1'b0;
        if (!bad && wr) mdl[ns] = (wd & WMASK) | FIXV;
        check(rsp_valid === 1'b1, "R9 rsp_valid", 32'(rsp_valid), 32'h1);
        check(rsp_err === bad, {tag, " R10 rsp_err"}, 32'(rsp_err), 32'(bad));
        check(rsp_rdata === exp_rd, {tag, " R10 rsp_rdata"}, rsp_rdata, exp_rd);
        if (!bad && !wr) begin
            check((rsp_rdata & Z_MSK) == 32'h0 && (rsp_rdata & 32'h00C5_0018) == 32'h00C5_0018,
                  "R6 reserved bits", rsp_rdata, exp_rd);
            check((rsp_rdata & 32'h180) == 32'h80, "R7 read-only bits", rsp_rdata & 32'h180, 32'h80);
        end
    endtask

    task automatic do_reset(input bit cfg);
        cfg_exc_state = cfg;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mdl[0] = FIXV | (32'(cfg) << 30);
        mdl[1] = mdl[0];
        check(rsp_valid === 1'b0, "R9 idle after reset", 32'(rsp_valid), 32'h0);
        access(1'b0, 2'd3, 1'b0, 32'h0, 1'b0);
        check(rsp_rdata === mdl[0], "R1 secure reset value", rsp_rdata, mdl[0]);
        access(1'b0, 2'd3, 1'b1, 32'h0, 1'b0);
        check(rsp_rdata === mdl[1], "R1 non-secure reset value", rsp_rdata, mdl[1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] pat;
        do_reset(1'b1);
        for (int p = 0; p < 40; p++) begin
            pat = (p < 32) ? (32'h1 << p) : $urandom();
            if (p == 32) pat = 32'hFFFF_FFFF;
            if (p == 33) pat = 32'h0;
            for (int lk = 0; lk < 2; lk++) begin
                for (int pv = 0; pv < 4; pv++) begin
                    for (int ns = 0; ns < 2; ns++) begin
                        access(1'b1, 2'(pv), ns[0], pat ^ (32'(pv) << 12), lk[0]);
                        access(1'b0, 2'(pv), ns[0], 32'h0, lk[0]);
                        access(1'b0, 2'd1, !ns[0], 32'h0, lk[0]);
                    end
                end
            end
        end
        // Idle cycle: no response without a request.
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9 no request no response", 32'(rsp_valid), 32'h0);
        do_reset(1'b0);
        access(1'b1, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b0);
        access(1'b0, 2'd2, 1'b0, 32'h0, 1'b0);
        check(rsp_rdata[30] === 1'b1, "R8 exception bit writable", 32'(rsp_rdata[30]), 32'h1);
        summary();
        $finish;
    end
endmodule